// File: doc/BRIEF.md
# Digit-Serial Normal-Basis Field Multiplier

This block multiplies two elements of the binary field GF(2^M). Elements are held in a type II optimal normal basis built on the prime P = 2M+1, where 2 must generate the nonzero residues modulo P. Both operands enter through one M-bit data port, one after the other. A product accumulates in the result register with every result bit advancing at the same time. In each busy cycle every result bit absorbs D more cross-product terms while both operand registers are squared (rotated). The logic between registers therefore does not depend on M. A product takes ceil(M/D) busy cycles.

A host issues commands on a 2-bit code: 0 idle, 1 load, 2 multiply, 3 square. Loads fill the first operand register and then the second, in alternation. Multiply clears the result register and starts the accumulation. When the multiply finishes, the product replaces the first operand, which always drives the output. Square rotates the first operand by one place in a single cycle. So results can be chained: square a product, or multiply it again by the retained second operand.

Top module: `nb_mul`

## Requirements
- R1: While reset is applied and in the first cycle after it, `dout_o` is zero and both `busy_o` and `done_o` are low.
- R2: With the block idle, load commands (code 1) alternate their target. The first load after reset, or after an accepted multiply, writes the first operand and appears on `dout_o` in the next cycle. The following load writes the second operand and leaves `dout_o` unchanged.
- R3: Port bit q holds the coefficient of beta^(2^(M-1-q)). After a multiply (code 2), `dout_o` equals the normal-basis product of the two loaded operands. This holds for every pair of operands, zero included.
- R4: `done_o` goes high exactly ceil(M/D) cycles after the edge that accepts a multiply. It stays high for exactly one cycle. `busy_o` is high in the cycles in between, and `done_o` is only ever raised as `busy_o` falls.
- R5: Swapping the order in which the two operands are loaded gives the same product.
- R6: Multiplying by the all-ones word, the field identity, returns the other operand.
- R7: A square command (code 3) given while idle makes `dout_o` its own right rotation by one bit in the next cycle. The result equals the element multiplied by itself.
- R8: While busy, load, square and multiply commands are ignored. Neither the product nor its latency changes, and the load alternation is left where it was.
- R9: A multiply leaves the second operand intact. A second multiply with no new load therefore returns the first product times that same operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 0 idle, 1 load, 2 multiply, 3 square |
| din_i | input | M | Operand word for load commands |
| dout_o | output | M | First operand register, which holds the product after a multiply |
| busy_o | output | 1 | High while a multiply is accumulating |
| done_o | output | 1 | One-cycle pulse when the product is on `dout_o` |

## Verification
The checker watches the timing and register transfers on every cycle. It checks the exact busy length before `done_o`, the single-cycle done pulse, the one-bit rotation on square, where each load lands, and that the load alternation is frozen while busy. The value of a product can only be shown by the bench's scenarios. They cover an exhaustive sweep of all operand pairs against an arithmetic model of the basis, commutativity, the identity element, squaring of every element, commands thrown at the block mid-multiply, and back-to-back multiplies that reuse the retained second operand.

// File: rtl/nb_mul_pkg.sv
package nb_mul_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_MUL  = 2'd2,
    CMD_SQR  = 2'd3
  } nb_cmd_e;

  // 2^e reduced modulo p
  function automatic int pow2_mod(input int e, input int p);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = (r * 2) % p;
    return r;
  endfunction

  // Coefficient of the lowest basis element in beta_u * beta_v for a
  // type II optimal normal basis of degree m (prime p = 2m+1).
  function automatic logic term_hit(input int u, input int v, input int m);
    int p, e_sum, e_dif;
    logic h_sum, h_dif;
    p     = 2 * m + 1;
    e_sum = (pow2_mod(u, p) + pow2_mod(v, p)) % p;
    e_dif = (pow2_mod(u, p) - pow2_mod(v, p) + p) % p;
    h_sum = (e_sum == 1) || (e_sum == p - 1);
    h_dif = (e_dif == 1) || (e_dif == p - 1);
    return h_sum ^ h_dif;
  endfunction

endpackage

// File: rtl/nb_mul_digit.sv
// One accumulation step: every result slot absorbs one cross-product term,
// then accumulator and both operands rotate up by one coefficient position.
module nb_mul_digit #(
  parameter int M = 5
) (
  input  logic         en_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] acc_i,
  output logic [M-1:0] a_o,
  output logic [M-1:0] b_o,
  output logic [M-1:0] acc_o
);

  function automatic logic [M*M-1:0] build_matrix();
    logic [M*M-1:0] r;
    r = '0;
    for (int s = 0; s < M; s++)
      for (int v = 0; v < M; v++)
        r[s*M+v] = nb_mul_pkg::term_hit(s, v, M);
    return r;
  endfunction

  localparam logic [M*M-1:0] LMAT = build_matrix();

  logic [M-1:0] b_view [M];
  logic [M-1:0] term;
  logic [M-1:0] sum;

  for (genvar s = 0; s < M; s++) begin : g_slot
    for (genvar v = 0; v < M; v++) begin : g_b
      assign b_view[s][v] = b_i[(v + s) % M];
    end
    assign term[s] = a_i[(2 * s) % M] & (^(LMAT[s*M +: M] & b_view[s]));
  end

  assign sum   = acc_i ^ term;
  assign acc_o = en_i ? {sum[M-2:0], sum[M-1]} : acc_i;
  assign a_o   = en_i ? {a_i[M-2:0], a_i[M-1]} : a_i;
  assign b_o   = en_i ? {b_i[M-2:0], b_i[M-1]} : b_i;

endmodule

// File: rtl/nb_mul_ctrl.sv
module nb_mul_ctrl #(
  parameter int M = 5,
  parameter int D = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [1:0]   cmd_i,
  output logic         busy_o,
  output logic         last_o,
  output logic         done_o,
  output logic [D-1:0] step_en_o
);
  import nb_mul_pkg::*;

  localparam int N  = (M + D - 1) / D;
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;

  assign last_o = busy_q && (cnt_q == CW'(N - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (nb_cmd_e'(cmd_i) == CMD_MUL) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  for (genvar d = 0; d < D; d++) begin : g_en
    assign step_en_o[d] = busy_q && ((int'(cnt_q) * D + d) < M);
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/nb_mul.sv
module nb_mul #(
  parameter int M = 5,
  parameter int D = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [1:0]   cmd_i,
  input  logic [M-1:0] din_i,
  output logic [M-1:0] dout_o,
  output logic         busy_o,
  output logic         done_o
);
  import nb_mul_pkg::*;

  // port order is highest power first; internal order is coefficient index
  function automatic logic [M-1:0] flip(input logic [M-1:0] x);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = x[M-1-i];
    return r;
  endfunction

  logic [M-1:0] a_q, b_q, c_q;
  logic         sel_b_q;
  logic         busy, last;
  logic [D-1:0] step_en;

  logic [M-1:0] a_ch [D+1];
  logic [M-1:0] b_ch [D+1];
  logic [M-1:0] c_ch [D+1];

  nb_mul_ctrl #(.M(M), .D(D)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cmd_i     (cmd_i),
    .busy_o    (busy),
    .last_o    (last),
    .done_o    (done_o),
    .step_en_o (step_en)
  );

  assign a_ch[0] = a_q;
  assign b_ch[0] = b_q;
  assign c_ch[0] = c_q;

  for (genvar d = 0; d < D; d++) begin : g_step
    nb_mul_digit #(.M(M)) u_digit (
      .en_i  (step_en[d]),
      .a_i   (a_ch[d]),
      .b_i   (b_ch[d]),
      .acc_i (c_ch[d]),
      .a_o   (a_ch[d+1]),
      .b_o   (b_ch[d+1]),
      .acc_o (c_ch[d+1])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      sel_b_q <= 1'b0;
    end else if (busy) begin
      a_q <= last ? c_ch[D] : a_ch[D];
      b_q <= b_ch[D];
      c_q <= c_ch[D];
    end else begin
      case (nb_cmd_e'(cmd_i))
        CMD_LOAD: begin
          if (sel_b_q) b_q <= flip(din_i);
          else         a_q <= flip(din_i);
          sel_b_q <= ~sel_b_q;
        end
        CMD_MUL: begin
          c_q     <= '0;
          sel_b_q <= 1'b0;
        end
        CMD_SQR: a_q <= {a_q[M-2:0], a_q[M-1]};
        default: ;
      endcase
    end
  end

  assign dout_o = flip(a_q);
  assign busy_o = busy;

endmodule

// File: rtl/nb_mul_chk.sv
module nb_mul_chk #(
  parameter int M = 5,
  parameter int D = 2
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [1:0]   cmd_i,
  input logic [M-1:0] din_i,
  input logic [M-1:0] dout_o,
  input logic         busy_o,
  input logic         done_o,
  input logic         sel_b_q
);
  localparam int N = (M + D - 1) / D;

  int           busy_len;
  logic [M-1:0] dout_rot;

  assign dout_rot = {dout_o[0], dout_o[M-1:1]};

  always_ff @(posedge clk_i) begin
    if (rst_i)       busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> busy_len == N); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o); // R4

  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o && $past(busy_o)); // R4

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && cmd_i == 2'd1 && !sel_b_q) |=> dout_o == $past(din_i)); // R2

  AST_LOAD_SECOND: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && cmd_i == 2'd1 && sel_b_q) |=> $stable(dout_o)); // R2

  AST_SQR_ROTATE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && cmd_i == 2'd3) |=> dout_o == $past(dout_rot)); // R7

  AST_BUSY_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && cmd_i == 2'd1) |=> $stable(sel_b_q)); // R8

endmodule

bind nb_mul nb_mul_chk #(.M(M), .D(D)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .cmd_i   (cmd_i),
  .din_i   (din_i),
  .dout_o  (dout_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sel_b_q (sel_b_q)
);

// File: tb/nb_mul_tb.sv
`timescale 1ns/1ps
module nb_mul_tb;
  localparam int M     = 5;
  localparam int D     = 2;
  localparam int N     = (M + D - 1) / D;
  localparam int P     = 2 * M + 1;
  localparam int SZ    = 1 << M;
  localparam int LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   cmd = 2'd0;
  logic [M-1:0] din = '0;
  logic [M-1:0] dout;
  logic         busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [M-1:0] prod [SZ][SZ];

  always #2.5 clk = ~clk;

  nb_mul #(.M(M), .D(D)) u_dut (
    .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .din_i(din),
    .dout_o(dout), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int p2(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * 2) % P;
    return r;
  endfunction

  // reference product by direct expansion of basis element pairs
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] r = '0;
    for (int k = 0; k < M; k++) begin
      logic acc = 1'b0;
      int tk = p2(k);
      for (int u = 0; u < M; u++)
        for (int v = 0; v < M; v++) begin
          int e1 = (p2(u) + p2(v)) % P;
          int e2 = (p2(u) - p2(v) + P) % P;
          logic h = ((e1 == tk) || (e1 == P - tk)) ^ ((e2 == tk) || (e2 == P - tk));
          acc ^= h & x[M-1-u] & y[M-1-v];
        end
      r[M-1-k] = acc;
    end
    return r;
  endfunction

  task automatic issue(input logic [1:0] c, input logic [M-1:0] d);
    @(negedge clk);
    cmd = c;
    din = d;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic run_mul(output logic [M-1:0] res, output int lat);
    issue(2'd2, '0);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 40);
    res = dout;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] r, r2;
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 dout in reset", dout, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dout after reset", dout, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);

    // R2: alternation of load targets
    issue(2'd1, 5'h13);
    chk("R2 first load visible", dout, 5'h13);
    issue(2'd1, 5'h0a);
    chk("R2 second load hidden", dout, 5'h13);
    issue(2'd1, 5'h07);
    chk("R2 third load to first operand", dout, 5'h07);
    issue(2'd1, 5'h1c);

    // R3/R4: exhaustive sweep
    for (int ia = 0; ia < SZ; ia++)
      for (int ib = 0; ib < SZ; ib++) begin
        issue(2'd1, M'(ia));
        issue(2'd1, M'(ib));
        run_mul(r, lat);
        prod[ia][ib] = r;
        chk("R3 product", r, ref_mul(M'(ia), M'(ib)));
        chk("R4 latency", lat, N);
        @(negedge clk);
        chk("R4 done single cycle", done, 0);
      end

    for (int ia = 0; ia < SZ; ia++) begin
      for (int ib = ia + 1; ib < SZ; ib++)
        chk("R5 commutative", prod[ia][ib], prod[ib][ia]);
      chk("R6 identity right", prod[ia][SZ-1], ia);
      chk("R6 identity left", prod[SZ-1][ia], ia);
    end

    // R7: squaring every element
    for (int ia = 0; ia < SZ; ia++) begin
      logic [M-1:0] x = M'(ia);
      issue(2'd1, x);
      issue(2'd3, '0);
      chk("R7 square rotation", dout, {x[0], x[M-1:1]});
      chk("R7 square product", dout, ref_mul(x, x));
      issue(2'd1, '0);
    end

    // R8: commands thrown in while busy
    issue(2'd1, 5'h16);
    issue(2'd1, 5'h0b);
    issue(2'd2, '0);
    cmd = 2'd1; din = 5'h1f;
    @(negedge clk);
    chk("R8 busy during multiply", busy, 1);
    cmd = 2'd3;
    @(negedge clk);
    cmd = 2'd2;
    @(negedge clk);
    chk("R8 latency unchanged", done, 1);
    chk("R8 product unchanged", dout, ref_mul(5'h16, 5'h0b));
    cmd = 2'd0;
    @(negedge clk);
    chk("R8 no restart", busy, 0);
    issue(2'd1, 5'h09);
    chk("R8 load alternation intact", dout, 5'h09);

    // R9: second operand retained across multiplies
    issue(2'd1, 5'h0b);
    run_mul(r, lat);
    chk("R9 first product", r, ref_mul(5'h09, 5'h0b));
    run_mul(r2, lat);
    chk("R9 chained product", r2, ref_mul(ref_mul(5'h09, 5'h0b), 5'h0b));
    chk("R9 chained latency", lat, N);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule